// File: doc/BRIEF.md
# Two-wire register access slave

This block is a slave on a two-wire (I2C-compatible) serial bus. It lets a bus master read and write a small set of on-chip registers through an 8-bit address pointer. Both bus lines go through synchronisers into the system clock domain, where the block finds start, repeated start and stop conditions. It answers to one fixed 7-bit device address and pulls SDA low through an open-drain enable for acknowledge bits and read data.

In a write transaction, the first byte after the device address sets the pointer. Each byte after that is stored at the pointer, and the pointer then steps up by one. In a read transaction, the block sends the register at the pointer. It steps the pointer and sends the next register only when the master acknowledges. A stop always returns the pointer to register zero, so a master can poll register zero with bare read transactions. Each byte that is stored also appears on a write strobe (`wr_valid`, `wr_addr`, `wr_data`). This strobe is valid-only with no ready: the bus cannot be stalled, so whatever consumes the strobe must accept it in the cycle it is asserted.

Top module: `i2c_regslave`

## Requirements
- R1: A start is SDA falling while SCL is high. A repeated start in the middle of a transaction is handled the same way and begins a new address byte, leaving the pointer unchanged.
- R2: The address byte is 7 address bits, MSB first, followed by a direction bit (0 = write, 1 = read). With the default address 0x48, the block pulls SDA low on the ninth clock for bytes 0x90 and 0x91. For any other address it does not acknowledge, and it ignores the rest of the transaction (no acknowledge, no stored data) until the next start.
- R3: In a write transaction, the first byte after the address byte loads the pointer and is acknowledged.
- R4: Each later write byte is acknowledged, stored at the pointer, and followed by a pointer increment. Consecutive bytes therefore fill consecutive registers. Each stored byte gives one single-cycle `wr_valid` pulse, with the register number and data, while SCL is low.
- R5: In a read transaction, the block sends the register at the pointer, MSB first. When the master acknowledges, the pointer increments and the next register follows.
- R6: When the master does not acknowledge a read byte, the block releases the bus and goes idle without moving the pointer. A repeated-start read then returns the same register again.
- R7: A stop (SDA rising while SCL is high) returns the block to idle and clears the pointer to 0x00, after both reads and writes.
- R8: Valid registers are 0x00 to NREG-1 (0x00 to 0x07 by default). A byte written outside this range is acknowledged but neither stored nor strobed. A read outside this range returns 0x00.
- R9: The pointer is 8 bits wide and wraps from 0xFF to 0x00.
- R10: After reset, SDA is released, no write strobe is active, the pointer is 0, and register i holds RST_BASE+i (0xA0+i by default).
- R11: The SDA drive changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| wr_valid | output | 1 | One-cycle strobe for a stored write byte |
| wr_addr | output | 3 | Register number of the stored byte |
| wr_data | output | 8 | Stored byte value |

## Verification
A vector table of single-byte writes, each followed by a readback, mixes in-range pointers with pointers just past the range and far past it. This separates storing a byte from only acknowledging it, and it shows that an out-of-range read returns zero rather than an aliased register. Directed sequences cover the rest. Multi-byte bursts in both directions separate auto-increment from overwriting one register. A NACK followed by a repeated-start read separates an increment on acknowledge from an increment on transmission. A read right after a stop shows that the pointer was cleared. A foreign address followed by data shows that the block ignores the transaction. A write at pointer 0xFF shows the wrap.

// File: rtl/i2c_regslave_pkg.sv
package i2c_regslave_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WDATA,
    ST_RDATA
  } slv_state_e;
endpackage

// File: rtl/i2c_regslave_sync.sv
module i2c_regslave_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] lvl_o,
  output logic [LINES-1:0] prev_o
);
  // bus lines idle high, so every stage resets to 1
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    logic              last;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= '1;
        last  <= 1'b1;
      end else begin
        chain <= {chain[STAGES-2:0], raw_i[g]};
        last  <= chain[STAGES-1];
      end
    end
    assign lvl_o[g]  = chain[STAGES-1];
    assign prev_o[g] = last;
  end
endmodule

// File: rtl/i2c_regslave_regs.sv
module i2c_regslave_regs #(
  parameter int         NREG     = 8,
  parameter int         DW       = 8,
  parameter int         PW       = 8,
  parameter int         AW       = 3,
  parameter logic [7:0] RST_BASE = 8'hA0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [PW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[i] <= DW'(RST_BASE + i);
      else if (we && waddr == AW'(i))
        mem[i] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (int'(raddr) < NREG)
      rdata = mem[raddr[AW-1:0]];
  end
endmodule

// File: rtl/i2c_regslave.sv
module i2c_regslave #(
  parameter logic [6:0] DEV_ADDR = 7'h48,
  parameter int         NREG     = 8,
  parameter logic [7:0] RST_BASE = 8'hA0,
  parameter int         SYNC_STG = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scl_i,
  input  logic                    sda_i,
  output logic                    sda_oe,
  output logic                    wr_valid,
  output logic [$clog2(NREG)-1:0] wr_addr,
  output logic [7:0]              wr_data
);
  import i2c_regslave_pkg::*;

  localparam int DW = 8;
  localparam int PW = 8;
  localparam int AW = $clog2(NREG);
  localparam int CW = 4;

  logic [1:0] lvl, prev;
  logic scl_s, sda_s, scl_p, sda_p;
  logic scl_rise, scl_fall, start_c, stop_c;

  i2c_regslave_sync #(.LINES(2), .STAGES(SYNC_STG)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  ({sda_i, scl_i}),
    .lvl_o  (lvl),
    .prev_o (prev)
  );

  assign scl_s    = lvl[0];
  assign sda_s    = lvl[1];
  assign scl_p    = prev[0];
  assign sda_p    = prev[1];
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_c  = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_c   = scl_s & scl_p & ~sda_p & sda_s;

  slv_state_e    st;
  logic [CW-1:0] bitcnt;
  logic [DW-1:0] rx, tx;
  logic [PW-1:0] ptr;
  logic          rw, mack, oe;
  logic [DW-1:0] rd_data;
  logic          in_idle;

  assign in_idle = (st == ST_IDLE);

  i2c_regslave_regs #(
    .NREG(NREG), .DW(DW), .PW(PW), .AW(AW), .RST_BASE(RST_BASE)
  ) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_valid),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (ptr),
    .rdata (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      bitcnt   <= '0;
      rx       <= '0;
      tx       <= '0;
      ptr      <= '0;
      rw       <= 1'b0;
      mack     <= 1'b0;
      oe       <= 1'b0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_valid <= 1'b0;
      if (stop_c) begin
        st     <= ST_IDLE;
        ptr    <= '0;
        oe     <= 1'b0;
        bitcnt <= '0;
      end else if (start_c) begin
        st     <= ST_ADDR;
        oe     <= 1'b0;
        bitcnt <= '0;
      end else if (st == ST_ADDR || st == ST_PTR || st == ST_WDATA) begin
        // receive path: bits counted on SCL rise, acknowledge on falls
        if (scl_rise) begin
          if (bitcnt < CW'(8))
            rx <= {rx[DW-2:0], sda_s};
          bitcnt <= bitcnt + 1'b1;
        end else if (scl_fall) begin
          if (bitcnt == CW'(8)) begin
            if (st == ST_ADDR) begin
              if (rx[7:1] == DEV_ADDR) begin
                oe <= 1'b1;
                rw <= rx[0];
              end else begin
                st <= ST_IDLE;
              end
            end else if (st == ST_PTR) begin
              oe  <= 1'b1;
              ptr <= rx;
            end else begin
              oe <= 1'b1;
              if (int'(ptr) < NREG) begin
                wr_valid <= 1'b1;
                wr_addr  <= ptr[AW-1:0];
                wr_data  <= rx;
              end
              ptr <= ptr + 1'b1;
            end
          end else if (bitcnt == CW'(9)) begin
            bitcnt <= '0;
            if (st == ST_ADDR && rw) begin
              st <= ST_RDATA;
              tx <= rd_data;
              oe <= ~rd_data[DW-1];
            end else begin
              oe <= 1'b0;
              st <= (st == ST_ADDR) ? ST_PTR : ST_WDATA;
            end
          end
        end
      end else if (st == ST_RDATA) begin
        // transmit path: bits change on falls, master ack sampled on rise
        if (scl_rise) begin
          if (bitcnt == CW'(8)) begin
            mack <= ~sda_s;
            if (!sda_s)
              ptr <= ptr + 1'b1;
          end
          bitcnt <= bitcnt + 1'b1;
        end else if (scl_fall) begin
          if (bitcnt >= CW'(1) && bitcnt <= CW'(7)) begin
            tx <= {tx[DW-2:0], 1'b0};
            oe <= ~tx[DW-2];
          end else if (bitcnt == CW'(8)) begin
            oe <= 1'b0;
          end else if (bitcnt == CW'(9)) begin
            bitcnt <= '0;
            if (mack) begin
              tx <= rd_data;
              oe <= ~rd_data[DW-1];
            end else begin
              st <= ST_IDLE;
              oe <= 1'b0;
            end
          end
        end
      end
    end
  end

  assign sda_oe = oe;
endmodule

// File: rtl/i2c_regslave_chk.sv
module i2c_regslave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic sda_oe,
  input logic wr_valid,
  input logic idle
);
  AST_SDA_HOLD_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    scl_s |-> $stable(sda_oe)); // R11
  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid); // R4
  AST_WR_IN_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !scl_s); // R4
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !sda_oe); // R2
endmodule

bind i2c_regslave i2c_regslave_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_s    (scl_s),
  .sda_oe   (sda_oe),
  .wr_valid (wr_valid),
  .idle     (in_idle)
);

// File: tb/i2c_regslave_test.sv
module i2c_regslave_test;
  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       m_sda = 1'b1;
  logic       sda_line;
  logic       sda_oe, wr_valid;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;

  int total = 0, bad = 0, n_wr = 0, r11_viol = 0;
  logic [2:0] last_wa;
  logic [7:0] last_wd;
  logic [7:0] mdl [8];
  logic       prev_oe = 1'b0;
  bit         finished = 0;

  always #5 clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  i2c_regslave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always @(negedge clk) begin
    if (wr_valid) begin
      n_wr++;
      last_wa = wr_addr;
      last_wd = wr_data;
    end
    if (scl && sda_oe != prev_oe) r11_viol++;
    prev_oe = sda_oe;
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bstart();
    m_sda = 1'b1; wq(Q); scl = 1'b1; wq(2*Q);
    m_sda = 1'b0; wq(2*Q); scl = 1'b0; wq(Q);
  endtask

  task automatic bstop();
    m_sda = 1'b0; wq(Q); scl = 1'b1; wq(2*Q); m_sda = 1'b1; wq(2*Q);
  endtask

  task automatic send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
    end
    m_sda = 1'b1; wq(Q); scl = 1'b1; wq(Q);
    ack = ~sda_line;
    wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic recv(input logic mack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q); scl = 1'b1; wq(Q); b[i] = sda_line; wq(Q); scl = 1'b0; wq(Q);
    end
    m_sda = ~mack; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
    m_sda = 1'b1;
  endtask

  // ptr, write data, expected readback
  localparam logic [23:0] VEC [5] = '{
    {8'h03, 8'h5C, 8'h5C},
    {8'h09, 8'h11, 8'h00},
    {8'h00, 8'hFF, 8'hFF},
    {8'h80, 8'h42, 8'h00},
    {8'h07, 8'h01, 8'h01}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic       a;
    logic [7:0] d;
    int         w0;
    for (int i = 0; i < 8; i++) mdl[i] = 8'hA0 + 8'(i);
    wq(5);
    check("R10 sda released in reset", int'(sda_oe), 0);
    check("R10 no strobe in reset", int'(wr_valid), 0);
    rst_n = 1'b1; wq(5);

    // R10 / R5: reset contents read as one burst from pointer 0
    bstart(); send(8'h91, a); check("R2 read address ack", int'(a), 1);
    for (int i = 0; i < 8; i++) begin
      recv(i != 7, d);
      check("R10 R5 reset value burst", int'(d), int'(mdl[i]));
    end
    bstop();

    // table walk: single writes and readbacks (R3 R4 R8)
    for (int v = 0; v < 5; v++) begin
      logic [7:0] p, wd, ex;
      {p, wd, ex} = VEC[v];
      w0 = n_wr;
      bstart(); send(8'h90, a); check("R2 write address ack", int'(a), 1);
      send(p, a); check("R3 pointer byte ack", int'(a), 1);
      send(wd, a); check("R4 R8 data byte ack", int'(a), 1);
      bstop();
      check("R4 R8 strobe count", n_wr - w0, (p < 8) ? 1 : 0);
      if (p < 8) begin
        mdl[p[2:0]] = wd;
        check("R4 strobe addr", int'(last_wa), int'(p[2:0]));
        check("R4 strobe data", int'(last_wd), int'(wd));
      end
      bstart(); send(8'h90, a); send(p, a);
      bstart(); send(8'h91, a); recv(1'b0, d); bstop();
      check("R8 R5 table readback", int'(d), int'(ex));
    end

    // burst write with auto-increment
    bstart(); send(8'h90, a); send(8'h05, a);
    send(8'h11, a); send(8'h22, a); send(8'h33, a); bstop();
    mdl[5] = 8'h11; mdl[6] = 8'h22; mdl[7] = 8'h33;
    bstart(); send(8'h90, a); send(8'h05, a);
    bstart(); send(8'h91, a);
    for (int i = 5; i < 8; i++) begin
      recv(i != 7, d);
      check("R4 burst write readback", int'(d), int'(mdl[i]));
    end
    bstop();

    // stop clears pointer
    bstart(); send(8'h90, a); send(8'h04, a); bstop();
    bstart(); send(8'h91, a); recv(1'b0, d); bstop();
    check("R7 read after stop is reg0", int'(d), int'(mdl[0]));

    // NACK keeps pointer; repeated start rereads
    bstart(); send(8'h90, a); send(8'h02, a);
    bstart(); send(8'h91, a); recv(1'b0, d);
    check("R5 first read reg2", int'(d), int'(mdl[2]));
    bstart(); send(8'h91, a); check("R1 repeated start ack", int'(a), 1);
    recv(1'b0, d); bstop();
    check("R6 R1 nack kept pointer", int'(d), int'(mdl[2]));

    // foreign address ignored
    w0 = n_wr;
    bstart(); send(8'h92, a); check("R2 foreign address nack", int'(a), 0);
    send(8'h03, a); check("R2 ignored byte nack", int'(a), 0);
    send(8'h77, a); check("R2 ignored data nack", int'(a), 0);
    bstop();
    check("R2 no strobe when ignored", n_wr - w0, 0);
    bstart(); send(8'h90, a); send(8'h03, a);
    bstart(); send(8'h91, a); recv(1'b0, d); bstop();
    check("R2 reg3 untouched", int'(d), int'(mdl[3]));

    // pointer wrap 0xFF -> 0x00
    w0 = n_wr;
    bstart(); send(8'h90, a); send(8'hFF, a);
    send(8'hAA, a); check("R8 out-of-range ack", int'(a), 1);
    send(8'h5A, a); bstop();
    mdl[0] = 8'h5A;
    check("R9 one strobe after wrap", n_wr - w0, 1);
    check("R9 wrap strobe addr", int'(last_wa), 0);
    bstart(); send(8'h91, a); recv(1'b0, d); bstop();
    check("R9 reg0 after wrap", int'(d), 8'h5A);

    // read past the range
    bstart(); send(8'h90, a); send(8'h06, a);
    bstart(); send(8'h91, a);
    for (int i = 6; i < 10; i++) begin
      recv(i != 9, d);
      check("R8 read past range", int'(d), (i < 8) ? int'(mdl[i]) : 0);
    end
    bstop();

    check("R11 sda steady while scl high", r11_viol, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule